// File: doc/BRIEF.md
# Memory-to-Memory ALU Sequencer

This block executes 16-bit instructions whose operands and result all sit in a small external data memory with a single port. It has no register file. An accepted instruction is split into an opcode, a destination address, two source addresses and a function code. The block then reads the first source and holds it in an operand register. It reads the second source in the next cycle, computes the result in a cycle of its own, and writes the result to the destination. Only after that does it signal completion.

A second opcode writes an 8-bit constant, carried in the instruction, straight into the destination word. This form performs no read. The two remaining opcodes complete as no-ops. Instructions arrive over a valid/ready handshake. While one instruction runs, the block accepts no other. The memory port gives combinational read data: `mem_rdata_i` reflects `mem_addr_o` in the same cycle. A write strobed by `mem_we_o` takes effect at the next rising clock edge.

Top module: `mm_alu_seq`

## Requirements
- R1: Instruction fields are, from bit 15 down: opcode [15:14], destination [13:10], first source [9:6], second source [5:2], function [1:0].
- R2: Opcode 00 is an ALU operation. Function 00 adds, 01 subtracts (first source minus second), 10 is bitwise AND and 11 is bitwise OR. Results wrap modulo 256.
- R3: An ALU instruction reads the first source in the cycle after acceptance and the second source in the cycle after that. A cycle never has both `mem_re_o` and `mem_we_o` high.
- R4: An ALU instruction writes the destination in one single cycle, four cycles after acceptance. That is two cycles after the second read, with one compute cycle between them.
- R5: When the destination equals one or both sources, the written value is computed from the operand values that were in memory before the write.
- R6: Opcode 01 writes the constant in bits [9:2] to the destination in the cycle after acceptance. It performs no memory read, and function bits [1:0] have no effect.
- R7: Opcodes 10 and 11 perform no memory read and no memory write.
- R8: `instr_ready_o` is high exactly when idle. An instruction is accepted on a rising edge with `instr_valid_i` and `instr_ready_o` both high. `busy_o` is high from the cycle after acceptance through the done cycle. A valid instruction presented while busy is ignored.
- R9: `done_o` is a one-cycle pulse. It comes 5 cycles after acceptance for an ALU instruction, 2 cycles after for an immediate write and 1 cycle after for a no-op. The block is idle again in the following cycle.
- R10: While reset is asserted and right after it is released, the block is idle: ready 1, busy 0, done 0, no read, no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction offered |
| instr_i | input | 16 | Instruction word |
| instr_ready_o | output | 1 | Block idle, can take an instruction |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Instruction completed (one-cycle pulse) |
| mem_addr_o | output | 4 | Memory word address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, combinational on mem_addr_o |

## Verification
The assertions take for granted that memory read data is valid in the same cycle as the address. They also assume that nothing other than this block writes the memory while an instruction is running. The bench memory model responds combinationally and applies writes only from the block's strobe, which keeps the stimulus inside those assumptions. The handshake assertions tolerate any `instr_valid_i` pattern. The bench therefore also holds valid high with an unrelated instruction throughout a busy window, to show that such input is dropped.

// File: rtl/mm_alu_pkg.sv
package mm_alu_pkg;

  typedef enum logic [1:0] {
    OP_ALU  = 2'b00,
    OP_IMM  = 2'b01,
    OP_RSV2 = 2'b10,
    OP_RSV3 = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } fn_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READA = 3'd1,
    ST_READB = 3'd2,
    ST_EXEC  = 3'd3,
    ST_WRITE = 3'd4,
    ST_DONE  = 3'd5
  } state_e;

endpackage

// File: rtl/mm_decode.sv
module mm_decode
  import mm_alu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int OPC_W  = 2,
  parameter int FN_W   = 2,
  localparam int INSTR_W = OPC_W + 3 * ADDR_W + FN_W,
  localparam int IMM_W   = 2 * ADDR_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  output opcode_e            opcode_o,
  output logic [ADDR_W-1:0]  dest_o,
  output logic [ADDR_W-1:0]  src1_o,
  output logic [ADDR_W-1:0]  src2_o,
  output fn_e                fn_o,
  output logic [IMM_W-1:0]   imm_o
);

  localparam int DEST_LSB = FN_W + 2 * ADDR_W;
  localparam int SRC1_LSB = FN_W + ADDR_W;
  localparam int SRC2_LSB = FN_W;

  assign opcode_o = opcode_e'(instr_i[INSTR_W-1 -: OPC_W]);
  assign dest_o   = instr_i[DEST_LSB +: ADDR_W];
  assign src1_o   = instr_i[SRC1_LSB +: ADDR_W];
  assign src2_o   = instr_i[SRC2_LSB +: ADDR_W];
  assign fn_o     = fn_e'(instr_i[FN_W-1:0]);
  // constant shares the two source fields
  assign imm_o    = instr_i[FN_W +: IMM_W];

endmodule

// File: rtl/mm_alu.sv
module mm_alu
  import mm_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  fn_e               fn_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    unique case (fn_i)
      FN_ADD:  res_o = a_i + b_i;
      FN_SUB:  res_o = a_i - b_i;
      FN_AND:  res_o = a_i & b_i;
      default: res_o = a_i | b_i;
    endcase
  end

endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_alu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    valid_i,
  input  opcode_e op_i,
  output logic    ready_o,
  output logic    busy_o,
  output logic    done_o,
  output logic    rd_a_o,
  output logic    rd_b_o,
  output logic    exec_o,
  output logic    wr_o
);

  state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (valid_i) begin
        unique case (op_i)
          OP_ALU:  st_d = ST_READA;
          OP_IMM:  st_d = ST_WRITE;
          default: st_d = ST_DONE;
        endcase
      end
      ST_READA: st_d = ST_READB;
      ST_READB: st_d = ST_EXEC;
      ST_EXEC:  st_d = ST_WRITE;
      ST_WRITE: st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign ready_o = (st_q == ST_IDLE);
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_DONE);
  assign rd_a_o  = (st_q == ST_READA);
  assign rd_b_o  = (st_q == ST_READB);
  assign exec_o  = (st_q == ST_EXEC);
  assign wr_o    = (st_q == ST_WRITE);

  // R9: done lasts one cycle and is followed by idle
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));

  // R8: a busy cycle never offers ready
  a_r8_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o);

  // R4: the compute cycle is followed by the write
  a_r4_exec_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> wr_o);

endmodule

// File: rtl/mm_alu_seq.sv
module mm_alu_seq
  import mm_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int OPC_W   = 2,
  localparam int FN_W    = 2,
  localparam int INSTR_W = OPC_W + 3 * ADDR_W + FN_W,
  localparam int IMM_W   = 2 * ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               instr_ready_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_re_o,
  output logic               mem_we_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);

  logic [INSTR_W-1:0] instr_q;
  logic [DATA_W-1:0]  op_a_q, op_b_q, res_q, alu_res, imm_data;
  logic               accept, rd_a, rd_b, exec, wr;
  opcode_e            in_op, q_op;
  fn_e                q_fn;
  logic [ADDR_W-1:0]  q_dest, q_src1, q_src2;
  logic [IMM_W-1:0]   q_imm;

  assign in_op  = opcode_e'(instr_i[INSTR_W-1 -: OPC_W]);
  assign accept = instr_valid_i && instr_ready_o;

  mm_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (instr_valid_i),
    .op_i    (in_op),
    .ready_o (instr_ready_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .rd_a_o  (rd_a),
    .rd_b_o  (rd_b),
    .exec_o  (exec),
    .wr_o    (wr)
  );

  mm_decode #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .FN_W(FN_W)) u_dec (
    .instr_i  (instr_q),
    .opcode_o (q_op),
    .dest_o   (q_dest),
    .src1_o   (q_src1),
    .src2_o   (q_src2),
    .fn_o     (q_fn),
    .imm_o    (q_imm)
  );

  mm_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i   (op_a_q),
    .b_i   (op_b_q),
    .fn_i  (q_fn),
    .res_o (alu_res)
  );

  generate
    if (IMM_W >= DATA_W) begin : g_imm_trunc
      assign imm_data = q_imm[DATA_W-1:0];
    end else begin : g_imm_ext
      assign imm_data = {{(DATA_W-IMM_W){1'b0}}, q_imm};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q <= '0;
      op_a_q  <= '0;
      op_b_q  <= '0;
      res_q   <= '0;
    end else begin
      if (accept) instr_q <= instr_i;
      if (rd_a)   op_a_q  <= mem_rdata_i;
      if (rd_b)   op_b_q  <= mem_rdata_i;
      if (exec)   res_q   <= alu_res;
    end
  end

  always_comb begin
    mem_addr_o = '0;
    if (rd_a)      mem_addr_o = q_src1;
    else if (rd_b) mem_addr_o = q_src2;
    else if (wr)   mem_addr_o = q_dest;
  end

  assign mem_re_o    = rd_a || rd_b;
  assign mem_we_o    = wr;
  assign mem_wdata_o = (q_op == OP_IMM) ? imm_data : res_q;

  // R3: single port, never read and write together
  a_r3_no_rw_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  // R3: reads always come as a back-to-back pair
  a_r3_reads_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_re_o) |=> mem_re_o);

  // R4: the write is followed directly by done
  a_r4_write_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> done_o);

  // R8: acceptance starts a busy window
  a_r8_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_ready_o) |=> busy_o);

  // R7: no memory traffic while idle
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_ready_o |-> !(mem_re_o || mem_we_o));

endmodule

// File: tb/mm_alu_seq_tb_top.sv
module mm_alu_seq_tb_top;

  typedef struct {
    bit       busy;
    bit       done;
    bit       re;
    bit       we;
    int       addr;
    int       wdata;
    string    tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        instr_ready_o, busy_o, done_o, mem_re_o, mem_we_o;
  logic [3:0]  mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;

  logic [7:0]  mem [16];
  int          ref_mem [16];
  exp_t        q [$];
  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;

  always #10 clk_i = ~clk_i;

  mm_alu_seq dut_i (
    .clk_i, .rst_ni, .instr_valid_i, .instr_i, .instr_ready_o, .busy_o,
    .done_o, .mem_addr_o, .mem_re_o, .mem_we_o, .mem_wdata_o, .mem_rdata_i
  );

  function automatic int init_val(int i);
    return (i * 37 + 11) % 256;
  endfunction

  assign mem_rdata_i = mem[mem_addr_o];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'(init_val(i));
    end else if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_cycle();
    exp_t e;
    if (q.size() > 0) e = q.pop_front();
    else e = '{busy: 0, done: 0, re: 0, we: 0, addr: 0, wdata: 0, tag: "R8"};
    chk(instr_ready_o == !e.busy, e.tag, "ready", int'(instr_ready_o), int'(!e.busy));
    chk(busy_o == e.busy, e.tag, "busy", int'(busy_o), int'(e.busy));
    chk(done_o == e.done, e.tag, "done", int'(done_o), int'(e.done));
    chk(mem_re_o == e.re, e.tag, "re", int'(mem_re_o), int'(e.re));
    chk(mem_we_o == e.we, e.tag, "we", int'(mem_we_o), int'(e.we));
    if (e.re || e.we)
      chk(int'(mem_addr_o) == e.addr, e.tag, "addr", int'(mem_addr_o), e.addr);
    if (e.we)
      chk(int'(mem_wdata_o) == e.wdata, e.tag, "wdata", int'(mem_wdata_o), e.wdata);
  endtask

  task automatic tick();
    @(posedge clk_i);
    #5;
    check_cycle();
  endtask

  function automatic logic [15:0] mk(int op, int d, int s1, int s2, int fn);
    return {2'(op), 4'(d), 4'(s1), 4'(s2), 2'(fn)};
  endfunction

  function automatic exp_t rec(bit re, bit we, int addr, int wdata, bit done,
                               string tag);
    exp_t e;
    e.busy = 1; e.re = re; e.we = we; e.addr = addr; e.wdata = wdata;
    e.done = done; e.tag = tag;
    return e;
  endfunction

  // build the expected cycle list from the requirements, update the reference
  task automatic plan(logic [15:0] ins, string tag);
    int op, d, s1, s2, fn, a, b, r;
    op = int'(ins[15:14]); d = int'(ins[13:10]);
    s1 = int'(ins[9:6]); s2 = int'(ins[5:2]); fn = int'(ins[1:0]);
    if (op == 0) begin
      a = ref_mem[s1]; b = ref_mem[s2];
      case (fn)
        0: r = (a + b) % 256;
        1: r = (a - b + 256) % 256;
        2: r = a & b;
        default: r = a | b;
      endcase
      q.push_back(rec(1, 0, s1, 0, 0, tag));
      q.push_back(rec(1, 0, s2, 0, 0, tag));
      q.push_back(rec(0, 0, 0, 0, 0, tag));
      q.push_back(rec(0, 1, d, r, 0, tag));
      q.push_back(rec(0, 0, 0, 0, 1, tag));
      ref_mem[d] = r;
    end else if (op == 1) begin
      r = int'(ins[9:2]);
      q.push_back(rec(0, 1, d, r, 0, tag));
      q.push_back(rec(0, 0, 0, 0, 1, tag));
      ref_mem[d] = r;
    end else begin
      q.push_back(rec(0, 0, 0, 0, 1, tag));
    end
  endtask

  task automatic check_mem(string tag);
    for (int i = 0; i < 16; i++)
      chk(int'(mem[i]) == ref_mem[i], tag, $sformatf("mem[%0d]", i),
          int'(mem[i]), ref_mem[i]);
  endtask

  // run one instruction; optionally keep valid high with junk while busy
  task automatic run(logic [15:0] ins, string tag, bit hold_junk = 0,
                     logic [15:0] junk = '0);
    plan(ins, tag);
    instr_valid_i = 1'b1;
    instr_i = ins;
    tick();
    if (hold_junk) instr_i = junk;
    else instr_valid_i = 1'b0;
    while (q.size() > 0) tick();
    instr_valid_i = 1'b0;
    tick();
    check_mem(tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = init_val(i);
    repeat (3) @(posedge clk_i);
    #5;
    check_cycle(); // R10 in reset
    rst_ni = 1'b1;
    tick();        // R10 after release
    check_mem("R10");

    run(mk(1, 3, 8'h00 >> 4, 4'h2 >> 2, 0), "R6");        // preload via imm
    run({2'b01, 4'd3, 8'd2, 2'b00}, "R6");
    run({2'b01, 4'd12, 8'd3, 2'b11}, "R6");               // fn bits ignored
    run(mk(0, 1, 3, 12, 0), "R2");                        // 2 + 3 = 5
    run({2'b01, 4'd4, 8'd200, 2'b01}, "R6");
    run({2'b01, 4'd5, 8'd100, 2'b10}, "R6");
    run(mk(0, 6, 4, 5, 0), "R2");                         // 200+100 wraps
    run(mk(0, 7, 3, 12, 1), "R2");                        // 2-3 wraps to 255
    run(mk(0, 8, 4, 6, 2), "R2");                         // AND
    run(mk(0, 9, 4, 5, 3), "R2");                         // OR
    run(mk(0, 3, 3, 12, 0), "R5");                        // dest == src1
    run(mk(0, 12, 4, 12, 1), "R5");                       // dest == src2
    run(mk(0, 10, 10, 10, 0), "R5");                      // all equal
    run(mk(2, 0, 1, 2, 3), "R7");
    run(mk(3, 15, 15, 15, 0), "R7");
    run(mk(0, 11, 13, 14, 0), "R8", 1'b1, mk(1, 11, 0, 0, 0)); // junk dropped
    run(mk(1, 2, 0, 0, 0), "R9", 1'b1, mk(3, 0, 0, 0, 0));
    run(mk(0, 0, 15, 1, 1), "R3");
    run(mk(0, 15, 0, 7, 0), "R4");
    run({2'b00, 4'd2, 4'd9, 4'd1, 2'b11}, "R1");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule